// File: doc/BRIEF.md
# PWM Brake Input Detector

This block is the fault front end of a PWM unit. It watches the external fault pins and the internal fault sources, recognises brake events, and raises the brake request that an output stage uses to force its outputs into a safe state. The forcing itself is done elsewhere.

There are two brake channels. Channel 0 ORs the event from its pin with the rising edges of up to three comparator outputs, each gated by its own enable bit. A channel 0 event latches a lock, and the brake request stays on until software releases that lock. Channel 1 takes its pin, a low-voltage-detect input, or both, as chosen by a source field. Its brake request follows the live level of the selected source.

Each pin path synchronises the pin and can invert it. It then passes it through a three-sample noise filter or a bypass around that filter, and finally through a falling-edge detector. Events set sticky flags that software clears by writing a one. A single interrupt line reports the flags when the brake interrupt is enabled.

Top module: `brake_detect`

## Requirements
- R1: When `pin_inv_i[n]` is 1, pin n is inverted before filtering and edge detection, so a rising edge on the raw pin is a brake event and a falling raw edge is not.
- R2: When `brk0_en_i` (or `brk1_en_i`) is 0, no new event on that channel sets its flag or lock. While `brk1_en_i` is 0, `brk_sts_o[1]` is 0.
- R3: A rising edge on `cmp_i[k]` is a channel 0 event only when `cmp_en_i[k]` is 1.
- R4: `b1_src_i` chooses the channel 1 source: 0 = pin 1, 1 = low-voltage input, 2 = both, 3 = none. The low-voltage input counts only while `lvd_en_i` is 1, and its rising edge is an event.
- R5: With the filter in use, a new pin level is accepted only after 3 equal consecutive samples. Samples are taken every 1, 2, 4 or 8 clocks for a select value of 0, 1, 2 or 3. A 2-clock low pulse at divide-by-1 and a 10-clock low pulse at divide-by-8 are rejected. A 4-clock and a 30-clock pulse are accepted.
- R6: With `filt_byp_i[n]` set, even a 1-clock low pulse is an event. A falling pin edge driven before clock edge 1 shows on `flag_o` after clock edge 3.
- R7: `flag_o[n]` is set by a channel n event and stays set until a cycle with `clr_flag_i[n]` = 1.
- R8: A channel 0 event sets `lock0_o`. `brk_sts_o[0]` stays 1 while the lock is held, even after the pin returns high and the flag is cleared. Only `clr_lock0_i` releases it.
- R9: `brk_sts_o[1]` is 1 while the selected channel 1 source is active (filtered pin low, or low-voltage input high) and returns to 0 when the source goes away.
- R10: `irq_o` is 1 one clock after `irq_en_i` is 1 and either flag is set, and 0 otherwise.
- R11: After reset, all flags, the lock, both status bits and the interrupt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| brk0_en_i | input | 1 | Channel 0 enable |
| brk1_en_i | input | 1 | Channel 1 enable |
| pin_inv_i | input | 2 | Per-pin inversion |
| filt_sel0_i | input | SEL_W | Pin 0 filter sample-rate select |
| filt_sel1_i | input | SEL_W | Pin 1 filter sample-rate select |
| filt_byp_i | input | 2 | Per-pin noise filter bypass |
| cmp_en_i | input | N_CMP | Comparator enables for channel 0 |
| lvd_en_i | input | 1 | Low-voltage input enable for channel 1 |
| b1_src_i | input | 2 | Channel 1 source select |
| irq_en_i | input | 1 | Brake interrupt enable |
| pin_i | input | 2 | Raw brake pins |
| cmp_i | input | N_CMP | Comparator outputs |
| lvd_i | input | 1 | Low-voltage detect input |
| clr_flag_i | input | 2 | Write-one-to-clear strobes for the flags |
| clr_lock0_i | input | 1 | Write-one-to-clear strobe for the lock |
| flag_o | output | 2 | Sticky brake flags |
| lock0_o | output | 1 | Channel 0 lock flag |
| brk_sts_o | output | 2 | Brake state per channel, also the brake request |
| irq_o | output | 1 | Brake interrupt |

## Verification
A wrong filter history or a wrong prescaler phase shows up as a pulse that is accepted or rejected against the R5 lengths. This is visible on `flag_o` within a few dozen clocks of the pulse. A wrong edge register or lost synchroniser stage moves the flag from the clock edge where R6 places it, so the mistake is caught in a single cycle. A lock that drops early, or a status bit that does not follow the source, shows on `brk_sts_o` at the next sample after the pin is released or the strobe is given. Gating errors (enables, source select, comparator enables) appear as a flag that is set when it must stay clear.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    B1_PIN  = 2'd0,
    B1_LVD  = 2'd1,
    B1_BOTH = 2'd2,
    B1_NONE = 2'd3
  } b1_src_e;
endpackage

// File: rtl/brk_sync.sv
module brk_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= {(STAGES*W){RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/brk_edge.sv
module brk_edge #(
  parameter bit   RISING  = 1'b0,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic evt
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= lvl;
  end

  generate
    if (RISING) begin : g_rise
      assign evt = ~prev_q & lvl;
    end else begin : g_fall
      assign evt = prev_q & ~lvl;
    end
  endgenerate

  AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    evt |=> (prev_q != $past(prev_q))); // R6
endmodule

// File: rtl/brk_filter.sv
module brk_filter #(
  parameter int SEL_W    = 2,
  parameter int FILT_LEN = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             bypass,
  output logic             lvl
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0]    pre_cnt;
  logic [CNT_W-1:0]    pre_mask;
  logic                tick;
  logic [FILT_LEN-1:0] hist_q;
  logic                filt_q;
  logic                all_hi;
  logic                all_lo;

  assign pre_mask = (CNT_W'(1) << div_sel) - CNT_W'(1);
  assign tick     = &(pre_cnt | ~pre_mask);
  assign all_hi   = &hist_q;
  assign all_lo   = ~|hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      hist_q  <= '1;
      filt_q  <= 1'b1;
    end else begin
      pre_cnt <= pre_cnt + CNT_W'(1);
      if (tick) hist_q <= {hist_q[FILT_LEN-2:0], din};
      if (all_hi)      filt_q <= 1'b1;
      else if (all_lo) filt_q <= 1'b0;
    end
  end

  assign lvl = bypass ? din : filt_q;

  AST_FILT_AGREES: assert property (@(posedge clk) disable iff (rst)
    (filt_q != $past(filt_q)) |-> ($past(all_hi) || $past(all_lo))); // R5
endmodule

// File: rtl/brk_pin_path.sv
module brk_pin_path #(
  parameter int SEL_W       = 2,
  parameter int FILT_LEN    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin,
  input  logic             invert,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             bypass,
  output logic             lvl,
  output logic             fall
);
  logic pin_c;
  logic pin_s;

  assign pin_c = pin ^ invert;

  brk_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(pin_c), .q(pin_s)
  );

  brk_filter #(.SEL_W(SEL_W), .FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(rst), .din(pin_s), .div_sel(div_sel), .bypass(bypass), .lvl(lvl)
  );

  brk_edge #(.RISING(1'b0), .RST_VAL(1'b1)) u_fall (
    .clk(clk), .rst(rst), .lvl(lvl), .evt(fall)
  );
endmodule

// File: rtl/brake_detect.sv
module brake_detect
  import brk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = 2,
  parameter int N_CMP       = 3,
  parameter int FILT_LEN    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             brk0_en_i,
  input  logic             brk1_en_i,
  input  logic [1:0]       pin_inv_i,
  input  logic [SEL_W-1:0] filt_sel0_i,
  input  logic [SEL_W-1:0] filt_sel1_i,
  input  logic [1:0]       filt_byp_i,
  input  logic [N_CMP-1:0] cmp_en_i,
  input  logic             lvd_en_i,
  input  logic [1:0]       b1_src_i,
  input  logic             irq_en_i,
  input  logic [1:0]       pin_i,
  input  logic [N_CMP-1:0] cmp_i,
  input  logic             lvd_i,
  input  logic [1:0]       clr_flag_i,
  input  logic             clr_lock0_i,
  output logic [1:0]       flag_o,
  output logic             lock0_o,
  output logic [1:0]       brk_sts_o,
  output logic             irq_o
);
  localparam int N_PIN = 2;

  logic [SEL_W-1:0] sel_arr [N_PIN];
  logic [N_PIN-1:0] pin_lvl;
  logic [N_PIN-1:0] pin_fall;
  logic [N_CMP-1:0] cmp_s;
  logic [N_CMP-1:0] cmp_rise;
  logic             lvd_s;
  logic             lvd_rise;

  assign sel_arr[0] = filt_sel0_i;
  assign sel_arr[1] = filt_sel1_i;

  generate
    for (genvar p = 0; p < N_PIN; p++) begin : g_pin
      brk_pin_path #(.SEL_W(SEL_W), .FILT_LEN(FILT_LEN), .SYNC_STAGES(SYNC_STAGES)) u_path (
        .clk(clk), .rst(rst), .pin(pin_i[p]), .invert(pin_inv_i[p]),
        .div_sel(sel_arr[p]), .bypass(filt_byp_i[p]),
        .lvl(pin_lvl[p]), .fall(pin_fall[p])
      );
    end
  endgenerate

  brk_sync #(.W(N_CMP), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cmp_sync (
    .clk(clk), .rst(rst), .d(cmp_i), .q(cmp_s)
  );

  generate
    for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
      brk_edge #(.RISING(1'b1), .RST_VAL(1'b0)) u_rise (
        .clk(clk), .rst(rst), .lvl(cmp_s[k]), .evt(cmp_rise[k])
      );
    end
  endgenerate

  brk_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lvd_sync (
    .clk(clk), .rst(rst), .d(lvd_i), .q(lvd_s)
  );

  brk_edge #(.RISING(1'b1), .RST_VAL(1'b0)) u_lvd_rise (
    .clk(clk), .rst(rst), .lvl(lvd_s), .evt(lvd_rise)
  );

  // channel event decode
  b1_src_e src;
  logic    use_pin1;
  logic    use_lvd;
  logic    ev0;
  logic    ev1;
  logic    b1_src_active;

  assign src      = b1_src_e'(b1_src_i);
  assign use_pin1 = (src == B1_PIN) || (src == B1_BOTH);
  assign use_lvd  = ((src == B1_LVD) || (src == B1_BOTH)) && lvd_en_i;

  assign ev0 = brk0_en_i & (pin_fall[0] | (|(cmp_en_i & cmp_rise)));
  assign ev1 = brk1_en_i & ((use_pin1 & pin_fall[1]) | (use_lvd & lvd_rise));
  assign b1_src_active = brk1_en_i & ((use_pin1 & ~pin_lvl[1]) | (use_lvd & lvd_s));

  // sticky state
  logic [1:0] flag_q;
  logic       lock0_q;
  logic       b1_act_q;
  logic       irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q   <= '0;
      lock0_q  <= 1'b0;
      b1_act_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (ev0)                flag_q[0] <= 1'b1;
      else if (clr_flag_i[0]) flag_q[0] <= 1'b0;
      if (ev1)                flag_q[1] <= 1'b1;
      else if (clr_flag_i[1]) flag_q[1] <= 1'b0;
      if (ev0)              lock0_q <= 1'b1;
      else if (clr_lock0_i) lock0_q <= 1'b0;
      b1_act_q <= b1_src_active;
      irq_q    <= irq_en_i & (|flag_q);
    end
  end

  assign flag_o    = flag_q;
  assign lock0_o   = lock0_q;
  assign brk_sts_o = {b1_act_q, lock0_q};
  assign irq_o     = irq_q;

  AST_FLAG0_SETS: assert property (@(posedge clk) disable iff (rst)
    ev0 |=> flag_o[0]); // R7
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (lock0_o && !clr_lock0_i) |=> lock0_o); // R8
  AST_LOCK_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(lock0_o) |-> $past(brk0_en_i)); // R2
  AST_B1_OFF: assert property (@(posedge clk) disable iff (rst)
    !brk1_en_i |=> !brk_sts_o[1]); // R2
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(irq_en_i) && $past(|flag_o))); // R10
endmodule

// File: tb/brake_detect_tb.sv
module brake_detect_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       brk0_en, brk1_en, lvd_en, irq_en, clr_lock0, lvd;
  logic [1:0] pin_inv, sel0, sel1, byp, b1_src, pin, clr_flag;
  logic [2:0] cmp_en, cmp;
  logic [1:0] flag, sts;
  logic       lock0, irq;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  brake_detect u_dut (
    .clk(clk), .rst(rst), .brk0_en_i(brk0_en), .brk1_en_i(brk1_en),
    .pin_inv_i(pin_inv), .filt_sel0_i(sel0), .filt_sel1_i(sel1), .filt_byp_i(byp),
    .cmp_en_i(cmp_en), .lvd_en_i(lvd_en), .b1_src_i(b1_src), .irq_en_i(irq_en),
    .pin_i(pin), .cmp_i(cmp), .lvd_i(lvd), .clr_flag_i(clr_flag), .clr_lock0_i(clr_lock0),
    .flag_o(flag), .lock0_o(lock0), .brk_sts_o(sts), .irq_o(irq)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_flag = 2'b11; clr_lock0 = 1'b1;
    @(negedge clk);
    clr_flag = 2'b00; clr_lock0 = 1'b0;
  endtask

  task automatic low_pulse(int idx, int n);
    @(negedge clk);
    pin[idx] = 1'b0;
    wait_n(n);
    pin[idx] = 1'b1;
  endtask

  task automatic t_reset();
    brk0_en = 1; brk1_en = 1; lvd_en = 0; irq_en = 0; clr_lock0 = 0; lvd = 0;
    pin_inv = 0; sel0 = 0; sel1 = 0; byp = 2'b11; b1_src = 2'd0; pin = 2'b11;
    clr_flag = 0; cmp_en = 0; cmp = 0;
    rst = 1'b1;
    wait_n(4);
    rst = 1'b0;
    wait_n(6);
    chk("R11 flags", {6'd0, flag}, 8'd0);
    chk("R11 lock", {7'd0, lock0}, 8'd0);
    chk("R11 status", {6'd0, sts}, 8'd0);
    chk("R11 irq", {7'd0, irq}, 8'd0);
  endtask

  task automatic t_latency_lock();
    @(negedge clk);
    pin[0] = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R6 flag not before edge 3", {7'd0, flag[0]}, 8'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R6 flag at edge 3", {7'd0, flag[0]}, 8'd1);
    chk("R8 lock set", {7'd0, lock0}, 8'd1);
    pin[0] = 1'b1;
    wait_n(10);
    chk("R7 flag sticky", {7'd0, flag[0]}, 8'd1);
    chk("R8 brake0 held", {7'd0, sts[0]}, 8'd1);
    @(negedge clk); clr_flag = 2'b01;
    @(negedge clk); clr_flag = 2'b00;
    chk("R7 flag cleared", {7'd0, flag[0]}, 8'd0);
    chk("R8 lock survives flag clear", {7'd0, sts[0]}, 8'd1);
    @(negedge clk); clr_lock0 = 1'b1;
    @(negedge clk); clr_lock0 = 1'b0;
    chk("R8 lock released", {6'd0, sts[0], lock0}, 8'd0);
  endtask

  task automatic t_bypass_glitch();
    low_pulse(0, 1);
    wait_n(6);
    chk("R6 one-clock pulse seen", {7'd0, flag[0]}, 8'd1);
    clear_all();
  endtask

  task automatic t_invert();
    @(negedge clk);
    pin_inv[0] = 1'b1; pin[0] = 1'b0;
    wait_n(6);
    chk("R1 inversion no spurious event", {7'd0, flag[0]}, 8'd0);
    pin[0] = 1'b1;
    wait_n(6);
    chk("R1 raw rise triggers", {7'd0, flag[0]}, 8'd1);
    clear_all();
    pin[0] = 1'b0;
    wait_n(6);
    chk("R1 raw fall ignored", {7'd0, flag[0]}, 8'd0);
    pin_inv[0] = 1'b0; pin[0] = 1'b1;
    wait_n(6);
    clear_all();
  endtask

  task automatic t_filter();
    @(negedge clk); byp[0] = 1'b0; sel0 = 2'd0;
    wait_n(8);
    low_pulse(0, 2); wait_n(20);
    chk("R5 div1 short pulse rejected", {7'd0, flag[0]}, 8'd0);
    low_pulse(0, 4); wait_n(20);
    chk("R5 div1 long pulse accepted", {7'd0, flag[0]}, 8'd1);
    clear_all();
    sel0 = 2'd3;
    wait_n(40);
    low_pulse(0, 10); wait_n(60);
    chk("R5 div8 short pulse rejected", {7'd0, flag[0]}, 8'd0);
    low_pulse(0, 30); wait_n(60);
    chk("R5 div8 long pulse accepted", {7'd0, flag[0]}, 8'd1);
    clear_all();
    byp[0] = 1'b1; sel0 = 2'd0;
    wait_n(4);
  endtask

  task automatic t_cmp();
    @(negedge clk); cmp_en = 3'b010; cmp = 3'b001;
    wait_n(6);
    chk("R3 disabled comparator ignored", {6'd0, flag[0], lock0}, 8'd0);
    cmp = 3'b011;
    wait_n(6);
    chk("R3 enabled comparator triggers", {6'd0, flag[0], lock0}, 8'd3);
    cmp = 3'b000; cmp_en = 3'b000;
    clear_all();
  endtask

  task automatic t_b1_src();
    @(negedge clk); b1_src = 2'd0;
    pin[1] = 1'b0;
    wait_n(6);
    chk("R4 pin source flag", {7'd0, flag[1]}, 8'd1);
    chk("R9 status follows pin low", {7'd0, sts[1]}, 8'd1);
    pin[1] = 1'b1;
    wait_n(6);
    chk("R9 status drops on release", {7'd0, sts[1]}, 8'd0);
    clear_all();
    b1_src = 2'd1; lvd_en = 1'b1;
    low_pulse(1, 3); wait_n(6);
    chk("R4 pin ignored in lvd mode", {7'd0, flag[1]}, 8'd0);
    lvd = 1'b1; wait_n(6);
    chk("R4 lvd triggers", {6'd0, flag[1], sts[1]}, 8'd3);
    lvd = 1'b0; wait_n(6);
    chk("R9 status follows lvd", {7'd0, sts[1]}, 8'd0);
    clear_all();
    lvd_en = 1'b0; lvd = 1'b1; wait_n(6);
    chk("R4 lvd without enable ignored", {6'd0, flag[1], sts[1]}, 8'd0);
    lvd = 1'b0;
    b1_src = 2'd3; lvd_en = 1'b1;
    pin[1] = 1'b0; wait_n(6);
    chk("R4 none source", {6'd0, flag[1], sts[1]}, 8'd0);
    pin[1] = 1'b1; lvd_en = 1'b0; b1_src = 2'd0;
    wait_n(6);
    clear_all();
  endtask

  task automatic t_enables();
    @(negedge clk); brk0_en = 1'b0; brk1_en = 1'b0;
    low_pulse(0, 3);
    pin[1] = 1'b0;
    wait_n(8);
    chk("R2 channel 0 disabled", {6'd0, flag[0], lock0}, 8'd0);
    chk("R2 channel 1 disabled", {6'd0, flag[1], sts[1]}, 8'd0);
    pin[1] = 1'b1;
    wait_n(6);
    brk0_en = 1'b1; brk1_en = 1'b1;
    wait_n(2);
  endtask

  task automatic t_irq();
    low_pulse(0, 1); wait_n(6);
    chk("R10 irq off when disabled", {7'd0, irq}, 8'd0);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R10 irq one clock after enable", {7'd0, irq}, 8'd1);
    clear_all();
    @(negedge clk);
    chk("R10 irq drops after clear", {7'd0, irq}, 8'd0);
    irq_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_latency_lock();
    t_bypass_glitch();
    t_invert();
    t_filter();
    t_cmp();
    t_b1_src();
    t_enables();
    t_irq();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule